// File: doc/BRIEF.md
# Serial Flash Command Mode Controller

This block is the command front end on the device side of a serial flash. It runs on a fast system clock and oversamples the serial clock, the active-low chip select and four data lanes. While chip select is low it assembles instruction bytes. It receives one bit per serial clock on lane 0 in standard mode, or one nibble per serial clock on all four lanes in quad mode. When chip select is released it judges the whole frame. It then updates the interface mode, the continuous-read (enhancement) state and the write enable latch.

A frame counts only if chip select rises on a byte boundary after at least one complete byte. Each counted frame produces a one-cycle accept or reject pulse, together with its opcode. Read data, the memory array and program or erase timing are handled elsewhere. Those parts only need the accept pulse and the opcode.

Top module: `sflash_cmd_front`

## Requirements
- R1: After a synchronous reset, quad_mode, enh_mode, wel, cmd_ok and cmd_bad are all 0 and cmd_op is 00h.
- R2: Bits are captured on rising sck while cs_n is low. In standard mode a byte is 8 edges with the MSB first on dio[0]. In quad mode a byte is 2 edges with the high nibble first on dio[3:0]. A counted frame gives exactly one of cmd_ok or cmd_bad, high for one clk cycle on the (SYNC_STAGES+1)-th rising clk edge after cs_n goes high. cmd_op takes the frame's first byte on that same edge, and the state outputs change on that edge too.
- R3: A single-byte 38h is accepted and sets quad_mode. It is also accepted while quad_mode is already set, and the state does not change.
- R4: 03h, 3Bh and BBh are rejected while quad_mode is 1 and accepted while it is 0.
- R5: A single-byte FFh is rejected in standard mode and changes nothing. In quad mode it is accepted. If enh_mode is 1, FFh clears only enh_mode. Otherwise it clears quad_mode.
- R6: A single-byte 06h is accepted and sets wel.
- R7: 02h, 20h, D8h, C7h, 60h and 01h are rejected when wel is 0. They are accepted when wel is 1, and acceptance clears wel.
- R8: A frame with no complete byte, or one whose chip select rises mid-byte, gives no pulse and changes no state or cmd_op.
- R9: 38h, FFh or 06h followed by further bytes in the same frame is rejected and has no effect.
- R10: EBh is rejected in standard mode. In quad mode it is rejected if the frame has fewer than 5 bytes. When accepted, enh_mode is set if the high nibble of the fifth byte is Ah and cleared otherwise.
- R11: Every opcode not named in R3 to R10 is rejected and has no effect.
- R12: sck edges while cs_n is high are ignored, and each frame starts from a clean byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, oversampled |
| cs_n | input | 1 | Active-low chip select |
| dio | input | 4 | Serial data lanes; only lane 0 is used in standard mode |
| quad_mode | output | 1 | 1 when instructions are received as nibbles |
| enh_mode | output | 1 | Continuous-read enhancement state |
| wel | output | 1 | Write enable latch |
| cmd_ok | output | 1 | One-cycle accept pulse |
| cmd_bad | output | 1 | One-cycle reject pulse |
| cmd_op | output | 8 | Opcode of the last counted frame |

## Verification
Every result comes from a chip-select release. Inputs pass through SYNC_STAGES sampling registers and one output register, so the pulse, the opcode and the new state all appear on the (SYNC_STAGES+1)-th clk edge after cs_n rises. The bench samples at the falling clk edge one cycle before that edge, where it requires silence. It samples again just after that edge, where it compares all outputs, and once more a cycle later, to confirm the pulse lasted one cycle. Expected outcomes come from a bench-side model of the rules, run over a full sweep of all 256 opcodes plus targeted frames for length, alignment and mode cases.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int LANES = 4;
  localparam int OPW = 8;
  localparam int MODE_IDX = 4;
  localparam int BCW = $clog2(MODE_IDX + 2);

  localparam logic [OPW-1:0] OP_QUAD_ON  = 8'h38;
  localparam logic [OPW-1:0] OP_QUAD_OFF = 8'hFF;
  localparam logic [OPW-1:0] OP_WEN      = 8'h06;
  localparam logic [OPW-1:0] OP_RD       = 8'h03;
  localparam logic [OPW-1:0] OP_RD_DO    = 8'h3B;
  localparam logic [OPW-1:0] OP_RD_DIO   = 8'hBB;
  localparam logic [OPW-1:0] OP_RD_QIO   = 8'hEB;
  localparam logic [OPW-1:0] OP_PROG     = 8'h02;
  localparam logic [OPW-1:0] OP_ERS_SEC  = 8'h20;
  localparam logic [OPW-1:0] OP_ERS_BLK  = 8'hD8;
  localparam logic [OPW-1:0] OP_ERS_ALL  = 8'hC7;
  localparam logic [OPW-1:0] OP_ERS_ALT  = 8'h60;
  localparam logic [OPW-1:0] OP_WR_STAT  = 8'h01;
  localparam logic [3:0]     ENH_KEY     = 4'hA;

  typedef struct packed {
    logic ok;
    logic bad;
    logic quad_set;
    logic quad_clr;
    logic wel_set;
    logic wel_clr;
    logic enh_set;
    logic enh_clr;
  } verdict_t;

  function automatic logic is_gated(input logic [OPW-1:0] op);
    return (op == OP_PROG) || (op == OP_ERS_SEC) || (op == OP_ERS_BLK) ||
           (op == OP_ERS_ALL) || (op == OP_ERS_ALT) || (op == OP_WR_STAT);
  endfunction

  function automatic logic is_narrow_read(input logic [OPW-1:0] op);
    return (op == OP_RD) || (op == OP_RD_DO) || (op == OP_RD_DIO);
  endfunction
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int STAGES = 2,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic [DW-1:0] dio,
  output logic          sck_rise,
  output logic          cs_rise,
  output logic          cs_act,
  output logic [DW-1:0] dat
);
  localparam int W = DW + 2;
  localparam logic [W-1:0] IDLE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] chain [STAGES];
  logic sck_prev, cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= IDLE;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      chain[0] <= {cs_n, sck, dio};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sck_prev <= chain[STAGES-1][DW];
      cs_prev  <= chain[STAGES-1][DW+1];
    end
  end

  assign sck_rise = chain[STAGES-1][DW] & ~sck_prev;
  assign cs_rise  = chain[STAGES-1][DW+1] & ~cs_prev;
  assign cs_act   = ~chain[STAGES-1][DW+1];
  assign dat      = chain[STAGES-1][DW-1:0];
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_rise,
  input  logic             cs_act,
  input  logic             quad,
  input  logic [LANES-1:0] dat,
  output logic [OPW-1:0]   op,
  output logic [3:0]       mode_hi,
  output logic [BCW-1:0]   nbytes,
  output logic             aligned
);
  localparam logic [BCW-1:0] NB_MAX = {BCW{1'b1}};

  logic [OPW-1:0] sh, sh_n;
  logic [2:0]     slot;
  logic           last;

  assign sh_n    = quad ? {sh[3:0], dat} : {sh[6:0], dat[0]};
  assign last    = quad ? (slot == 3'd1) : (slot == 3'd7);
  assign aligned = (slot == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      op      <= '0;
      mode_hi <= '0;
    end else if (cs_act && sck_rise && last) begin
      if (nbytes == '0) op <= sh_n;
      if (nbytes == BCW'(MODE_IDX)) mode_hi <= sh_n[7:4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sh     <= '0;
      slot   <= '0;
      nbytes <= '0;
    end else if (sck_rise) begin
      sh <= sh_n;
      if (last) begin
        slot <= '0;
        if (nbytes != NB_MAX) nbytes <= nbytes + 1'b1;
      end else begin
        slot <= slot + 3'd1;
      end
    end
  end

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
    (quad && cs_act) |-> (slot < 3'd2));
endmodule

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [3:0]     mode_hi,
  input  logic [BCW-1:0] nbytes,
  input  logic           quad,
  input  logic           enh,
  input  logic           wel,
  output verdict_t       v
);
  logic single, long_enough;
  assign single      = (nbytes == BCW'(1));
  assign long_enough = (nbytes >= BCW'(MODE_IDX + 1));

  always_comb begin
    v = '0;
    if (is_gated(op)) begin
      v.ok      = wel;
      v.bad     = ~wel;
      v.wel_clr = wel;
    end else if (is_narrow_read(op)) begin
      v.ok  = ~quad;
      v.bad = quad;
    end else begin
      case (op)
        OP_QUAD_ON: begin
          v.ok       = single;
          v.bad      = ~single;
          v.quad_set = single;
        end
        OP_QUAD_OFF: begin
          v.ok       = single & quad;
          v.bad      = ~(single & quad);
          v.enh_clr  = single & quad & enh;
          v.quad_clr = single & quad & ~enh;
        end
        OP_WEN: begin
          v.ok      = single;
          v.bad     = ~single;
          v.wel_set = single;
        end
        OP_RD_QIO: begin
          v.ok      = quad & long_enough;
          v.bad     = ~(quad & long_enough);
          v.enh_set = quad & long_enough & (mode_hi == ENH_KEY);
          v.enh_clr = quad & long_enough & (mode_hi != ENH_KEY);
        end
        default: v.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic [LANES-1:0] dio,
  output logic             quad_mode,
  output logic             enh_mode,
  output logic             wel,
  output logic             cmd_ok,
  output logic             cmd_bad,
  output logic [OPW-1:0]   cmd_op
);
  logic             sck_rise, cs_rise, cs_act, aligned;
  logic [LANES-1:0] dat;
  logic [OPW-1:0]   op;
  logic [3:0]       mode_hi;
  logic [BCW-1:0]   nbytes;
  verdict_t         v;
  logic             take;

  sfc_sync #(.STAGES(SYNC_STAGES), .DW(LANES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .dio(dio),
    .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_act(cs_act), .dat(dat)
  );

  sfc_shift u_shift (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_act(cs_act),
    .quad(quad_mode), .dat(dat), .op(op), .mode_hi(mode_hi),
    .nbytes(nbytes), .aligned(aligned)
  );

  sfc_decode u_dec (
    .op(op), .mode_hi(mode_hi), .nbytes(nbytes), .quad(quad_mode),
    .enh(enh_mode), .wel(wel), .v(v)
  );

  assign take = cs_rise && (nbytes != '0) && aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_mode <= 1'b0;
      enh_mode  <= 1'b0;
      wel       <= 1'b0;
      cmd_ok    <= 1'b0;
      cmd_bad   <= 1'b0;
      cmd_op    <= '0;
    end else begin
      cmd_ok  <= 1'b0;
      cmd_bad <= 1'b0;
      if (take) begin
        cmd_ok  <= v.ok;
        cmd_bad <= v.bad;
        cmd_op  <= op;
        if (v.quad_set) quad_mode <= 1'b1;
        if (v.quad_clr) quad_mode <= 1'b0;
        if (v.enh_set)  enh_mode  <= 1'b1;
        if (v.enh_clr)  enh_mode  <= 1'b0;
        if (v.wel_set)  wel       <= 1'b1;
        if (v.wel_clr)  wel       <= 1'b0;
      end
    end
  end

  assert_one_verdict_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ok && cmd_bad));
  assert_quad_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(quad_mode) |-> (cmd_ok && cmd_op == OP_QUAD_ON));
  assert_narrow_read_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && is_narrow_read(cmd_op)) |-> !$past(quad_mode));
  assert_quad_exit_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(quad_mode) |-> (cmd_ok && cmd_op == OP_QUAD_OFF && !$past(enh_mode)));
  assert_wel_set_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> (cmd_ok && cmd_op == OP_WEN));
  assert_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && is_gated(cmd_op)) |-> ($past(wel) && !wel));
  assert_enh_in_quad_R10: assert property (@(posedge clk) disable iff (rst)
    enh_mode |-> quad_mode);
endmodule

// File: tb/sim_sflash_cmd_front.sv
module sim_sflash_cmd_front;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int HOLD = 2;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1;
  logic [3:0] dio = '0;
  logic quad_mode, enh_mode, wel, cmd_ok, cmd_bad;
  logic [7:0] cmd_op;

  sflash_cmd_front #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .dio(dio),
    .quad_mode(quad_mode), .enh_mode(enh_mode), .wel(wel),
    .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .cmd_op(cmd_op)
  );

  always #4 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;
  bit m_quad = 0, m_enh = 0, m_wel = 0, e_ok = 0, e_bad = 0;
  logic [7:0] m_op = '0;
  logic [7:0] fb [8];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic predict(input int nb, input bit algn);
    logic [7:0] op;
    bit one;
    op = fb[0];
    one = (nb == 1);
    e_ok = 0;
    e_bad = 0;
    if (nb == 0 || !algn) return;
    m_op = op;
    case (op)
      8'h38: if (one) begin e_ok = 1; m_quad = 1; end else e_bad = 1;
      8'hFF: if (one && m_quad) begin
               e_ok = 1;
               if (m_enh) m_enh = 0; else m_quad = 0;
             end else e_bad = 1;
      8'h06: if (one) begin e_ok = 1; m_wel = 1; end else e_bad = 1;
      8'h03, 8'h3B, 8'hBB: if (m_quad) e_bad = 1; else e_ok = 1;
      8'hEB: if (m_quad && nb >= 5) begin
               e_ok = 1;
               m_enh = (fb[4][7:4] == 4'hA);
             end else e_bad = 1;
      8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60, 8'h01:
             if (m_wel) begin e_ok = 1; m_wel = 0; end else e_bad = 1;
      default: e_bad = 1;
    endcase
  endtask

  task automatic pulse_sck(input logic [3:0] d);
    dio = d;
    sck = 1'b0;
    repeat (HOLD) @(negedge clk);
    sck = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic frame(input int nb, input int xs, input string req);
    int per;
    per = m_quad ? 2 : 8;
    @(negedge clk);
    cs_n = 1'b0;
    sck = 1'b0;
    repeat (HOLD) @(negedge clk);
    for (int b = 0; b < nb; b++)
      for (int s = 0; s < per; s++)
        if (m_quad) pulse_sck((s == 0) ? fb[b][7:4] : fb[b][3:0]);
        else pulse_sck({3'b000, fb[b][7-s]});
    for (int x = 0; x < xs; x++) pulse_sck(4'h5);
    cs_n = 1'b1;
    predict(nb, xs == 0);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check(req, "pulse early", {cmd_ok, cmd_bad}, 2'b00);
    @(negedge clk);
    check(req, "cmd_ok", cmd_ok, e_ok);
    check(req, "cmd_bad", cmd_bad, e_bad);
    check(req, "cmd_op", cmd_op, m_op);
    check(req, "quad_mode", quad_mode, m_quad);
    check(req, "enh_mode", enh_mode, m_enh);
    check(req, "wel", wel, m_wel);
    @(negedge clk);
    check(req, "pulse width", {cmd_ok, cmd_bad}, 2'b00);
    sck = 1'b0;
    dio = '0;
  endtask

  task automatic one_op(input logic [7:0] op, input string req);
    fb[0] = op;
    frame(1, 0, req);
  endtask

  task automatic qio_read(input int nb, input logic [7:0] mb, input string req);
    fb[0] = 8'hEB; fb[1] = 8'h12; fb[2] = 8'h34; fb[3] = 8'h56; fb[4] = mb;
    frame(nb, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "quad_mode", quad_mode, 0);
    check("R1", "enh_mode", enh_mode, 0);
    check("R1", "wel", wel, 0);
    check("R1", "pulses", {cmd_ok, cmd_bad}, 0);
    check("R1", "cmd_op", cmd_op, 0);

    // R7 gated without latch, R6 latch set, R2 framing in standard mode
    one_op(8'h02, "R7 gated wel=0");
    one_op(8'h06, "R6 write enable");
    fb[0] = 8'h20; fb[1] = 8'h01; fb[2] = 8'h02; fb[3] = 8'h03;
    frame(4, 0, "R7 R2 erase with address");
    foreach (fb[i]) fb[i] = '0;
    // R7 each gated opcode
    one_op(8'h06, "R6"); one_op(8'hD8, "R7 block");
    one_op(8'h06, "R6"); one_op(8'hC7, "R7 chip");
    one_op(8'h06, "R6"); one_op(8'h60, "R7 chip alt");
    one_op(8'h06, "R6"); one_op(8'h01, "R7 status");
    one_op(8'h01, "R7 second without latch");
    // R4 reads allowed in standard mode
    one_op(8'h03, "R4 std"); one_op(8'h3B, "R4 std"); one_op(8'hBB, "R4 std");
    // R5 FFh in standard mode, R10 EBh in standard mode
    one_op(8'hFF, "R5 std");
    qio_read(5, 8'hA0, "R10 std");
    // R8 misaligned and empty frames
    fb[0] = 8'h38; frame(1, 3, "R8 misaligned");
    frame(0, 0, "R8 empty");
    frame(0, 5, "R8 partial byte");
    // R9 single-byte command with trailing byte
    fb[0] = 8'h38; fb[1] = 8'h00; frame(2, 0, "R9 extra byte");
    fb[0] = 8'h06; frame(2, 0, "R9 extra byte wen");
    // R12 stray sck edges while deselected
    for (int k = 0; k < 3; k++) pulse_sck(4'hF);
    sck = 1'b0;
    one_op(8'h38, "R12 R3 enter quad");
    one_op(8'h38, "R3 repeat in quad");
    one_op(8'h03, "R4 quad"); one_op(8'h3B, "R4 quad"); one_op(8'hBB, "R4 quad");
    one_op(8'h06, "R6 quad"); one_op(8'h02, "R7 R2 quad nibble");
    fb[0] = 8'hFF; frame(1, 1, "R8 quad misaligned");
    qio_read(4, 8'hA0, "R10 short");
    qio_read(5, 8'hA5, "R10 enter enh");
    qio_read(6, 8'h50, "R10 key mismatch");
    qio_read(5, 8'hAF, "R10 re-enter");
    fb[0] = 8'hFF; fb[1] = 8'hFF; frame(2, 0, "R9 R5 two-byte FF");
    one_op(8'hFF, "R5 first FF clears enh");
    one_op(8'hFF, "R5 second FF leaves quad");
    // R11 exhaustive opcode sweep, state carried across
    for (int o = 0; o < 256; o++) begin
      fb[0] = o[7:0];
      frame(1, 0, "R11 sweep");
    end
    one_op(8'hFF, "R5 after sweep");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule